// File: doc/BRIEF.md
# AXI4 Read Traffic Benchmark Engine

This block is a read-side load generator for characterising one memory channel over an AXI4 master read port. A run is armed with a start pulse together with a base address, an address stride counted in 64-byte words, a requested burst length and a total request count. The engine then issues that many read bursts, one beat of 64 bytes per data transfer. It accepts every returned beat as soon as it arrives.

While the run is active the engine measures the round-trip latency of each request, in clock cycles from the address handshake to the handshake of that request's last data beat. It keeps the smallest and largest latency and the sum of all latencies. It also adds the number of requests in flight into a wide accumulator on every active cycle and counts those cycles. Software divides the accumulated sums by the request count or by the active cycle count to get average latency and average depth. A programmable cap limits how many requests may be outstanding, so the same channel can be measured at several pipelining depths.

Responses are assumed to return in request order on a single ID. The issue timestamp of each request is held in a small FIFO until its last beat comes back.

Top module: `rd_bench_engine`

## Requirements
- R1: Request k of a run (k counted from 0) carries address base + k*stride*64 modulo 2^ADDR_W, with the six low base bits forced to zero. ARSIZE is always 6 (64-byte beats) and ARBURST is always 1 (incrementing).
- R2: ARLEN equals the configured length clipped to 63 - address[11:6], so that no burst crosses a 4 KB boundary or exceeds 64 beats.
- R3: A run issues exactly the configured number of requests, and the beat result equals the number of data handshakes in the run.
- R4: Once ARVALID is raised, it stays high with the same address and length until ARREADY is seen.
- R5: The number of requests accepted but not yet completed never exceeds the cap. A cap of 0, or one above DEPTH, means DEPTH.
- R6: The latency of a request is the number of rising edges from its address handshake to the handshake of its last beat. The minimum, maximum and sum over the run are reported.
- R7: The occupancy sum adds the in-flight count once per edge, from the edge after the first address handshake through the edge of the final last-beat handshake. The active cycle result counts those same edges, so the occupancy sum equals the latency sum.
- R8: The peak result is the largest in-flight count seen during the run.
- R9: RREADY is high during the whole run and low outside it, and the busy output follows the same span.
- R10: The done output rises, and busy falls, only after every issued request has fully returned. Done stays high until the next accepted start.
- R11: A start pulse while busy is ignored. Configuration is sampled only when a start is accepted.
- R12: A run with a request count of 0 finishes without issuing. Its counters read zero and the latency minimum reads all ones.
- R13: After reset the engine is idle, with busy, done, ARVALID and RREADY low, the counters at zero and the latency minimum at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start pulse, taken only while idle |
| cfg_base | input | ADDR_W | Run start address |
| cfg_stride | input | STRIDE_W | Address step in 64-byte words |
| cfg_len | input | 8 | Requested ARLEN |
| cfg_count | input | CNT_W | Requests in the run |
| cfg_cap | input | clog2(DEPTH+1) | Outstanding-request cap (0 = DEPTH) |
| run_busy | output | 1 | Run in progress |
| run_done | output | 1 | Last run finished |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Burst length minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rlast | input | 1 | Last beat of a burst |
| m_rready | output | 1 | Read data ready |
| res_beats | output | SUM_W | Data beats received |
| res_lat_min | output | LAT_W | Smallest request latency |
| res_lat_max | output | LAT_W | Largest request latency |
| res_lat_sum | output | SUM_W | Sum of request latencies |
| res_occ_sum | output | SUM_W | Accumulated in-flight count |
| res_act_cyc | output | SUM_W | Cycles accumulated into the occupancy sum |
| res_peak | output | clog2(DEPTH+1) | Peak in-flight count |

## Verification
The engine is driven against a responder model that has random response delay, random address-ready gaps and random data gaps. The sequential single-beat pattern at full cap shows whether latency and occupancy accounting line up when the responder's own acceptance depth is the limit. Multi-beat bursts with a small cap show whether the cap stalls issue. A base sitting at the last word of a 4 KB page, a zero stride with an oversized length, and a base near the top of the address space tell apart correct page clipping, length saturation and address wraparound. A zero-count run, a single-request cap and a start pulse issued mid-run separate the degenerate and ignore cases from the normal flow.

// File: rtl/rbe_pkg.sv
package rbe_pkg;

    // one data beat is 64 bytes; address pages are 4 KB
    localparam int BEAT_LG2       = 6;
    localparam int PAGE_LG2       = 12;
    localparam int PAGE_BEATS_LG2 = PAGE_LG2 - BEAT_LG2;
    localparam int AXLEN_W        = 8;

    localparam logic [2:0] AXSIZE_BEAT  = 3'd6;
    localparam logic [1:0] AXBURST_INCR = 2'b01;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

endpackage

// File: rtl/rbe_addr_gen.sv
module rbe_addr_gen
    import rbe_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int STRIDE_W = 24,
    parameter int CNT_W    = 32,
    parameter int OCC_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch_i,
    input  logic                run_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [AXLEN_W-1:0]  len_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [OCC_W-1:0]    cap_i,
    input  logic [OCC_W-1:0]    out_nxt_i,
    input  logic                arready_i,
    output logic                arvalid_o,
    output logic [ADDR_W-1:0]   araddr_o,
    output logic [AXLEN_W-1:0]  arlen_o,
    output logic                fire_o,
    output logic                all_issued_o
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << BEAT_LG2) - 1);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  issued;
    } ag_t;

    ag_t                       ag_d, ag_q;
    logic [ADDR_W-1:0]         step;
    logic                      fire;
    logic [PAGE_BEATS_LG2-1:0] page_room;

    always_comb begin
        ag_d = ag_q;
        step = ADDR_W'({stride_i, {BEAT_LG2{1'b0}}});
        fire = ag_q.vld & arready_i;
        if (launch_i) begin
            ag_d.vld    = 1'b0;
            ag_d.addr   = base_i & ALIGN_MASK;
            ag_d.issued = '0;
        end else if (run_i) begin
            if (fire) begin
                ag_d.addr   = ag_q.addr + step;
                ag_d.issued = ag_q.issued + 1'b1;
            end
            // a raised request is held until accepted
            if (!ag_q.vld || fire) begin
                ag_d.vld = (ag_d.issued != count_i) && (out_nxt_i < cap_i);
            end
        end
        // beats left before the next 4 KB boundary, minus one
        page_room = ~ag_q.addr[PAGE_LG2-1:BEAT_LG2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign arvalid_o    = ag_q.vld;
    assign araddr_o     = ag_q.addr;
    assign arlen_o      = (len_i > AXLEN_W'(page_room)) ? AXLEN_W'(page_room) : len_i;
    assign fire_o       = fire;
    assign all_issued_o = (ag_q.issued == count_i);

endmodule

// File: rtl/rbe_stamp_fifo.sv
module rbe_stamp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     dout_o,
    output logic [OCC_W-1:0] count_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [OCC_W-1:0] cnt;
    } ff_t;

    ff_t          ff_d, ff_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        ff_d = ff_q;
        if (clr_i) begin
            ff_d = '0;
        end else begin
            if (push_i) ff_d.wptr = (ff_q.wptr == LAST) ? '0 : ff_q.wptr + 1'b1;
            if (pop_i)  ff_d.rptr = (ff_q.rptr == LAST) ? '0 : ff_q.rptr + 1'b1;
            ff_d.cnt = ff_q.cnt + OCC_W'(push_i) - OCC_W'(pop_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    always_ff @(posedge clk) begin
        if (push_i && !clr_i) mem_q[ff_q.wptr] <= din_i;
    end

    assign dout_o  = mem_q[ff_q.rptr];
    assign count_o = ff_q.cnt;

endmodule

// File: rtl/rbe_stats.sv
module rbe_stats #(
    parameter int LAT_W = 32,
    parameter int SUM_W = 64,
    parameter int OCC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             finished_i,
    input  logic             ar_fire_i,
    input  logic             r_fire_i,
    input  logic             r_last_i,
    input  logic [LAT_W-1:0] stamp_i,
    input  logic [OCC_W-1:0] out_cnt_i,
    output logic [LAT_W-1:0] now_o,
    output logic [SUM_W-1:0] beats_o,
    output logic [LAT_W-1:0] lat_min_o,
    output logic [LAT_W-1:0] lat_max_o,
    output logic [SUM_W-1:0] lat_sum_o,
    output logic [SUM_W-1:0] occ_sum_o,
    output logic [SUM_W-1:0] act_cyc_o,
    output logic [OCC_W-1:0] peak_o
);

    typedef struct packed {
        logic [LAT_W-1:0] now;
        logic             active;
        logic [SUM_W-1:0] beats;
        logic [LAT_W-1:0] lmin;
        logic [LAT_W-1:0] lmax;
        logic [SUM_W-1:0] lsum;
        logic [SUM_W-1:0] osum;
        logic [SUM_W-1:0] acyc;
        logic [OCC_W-1:0] peak;
    } st_t;

    localparam st_t ST_CLR = '{now: '0, active: 1'b0, beats: '0, lmin: '1, lmax: '0,
                               lsum: '0, osum: '0, acyc: '0, peak: '0};

    st_t              st_d, st_q;
    logic [LAT_W-1:0] lat;

    always_comb begin
        st_d = st_q;
        lat  = st_q.now - stamp_i;
        if (clr_i) begin
            st_d = ST_CLR;
        end else if (run_i) begin
            st_d.now = st_q.now + 1'b1;
            if (ar_fire_i) st_d.active = 1'b1;
            // integrate occupancy from first issue to final return
            if (st_q.active && !finished_i) begin
                st_d.osum = st_q.osum + SUM_W'(out_cnt_i);
                st_d.acyc = st_q.acyc + 1'b1;
            end
            if (r_fire_i) st_d.beats = st_q.beats + 1'b1;
            if (r_last_i) begin
                if (lat < st_q.lmin) st_d.lmin = lat;
                if (lat > st_q.lmax) st_d.lmax = lat;
                st_d.lsum = st_q.lsum + SUM_W'(lat);
            end
            if (out_cnt_i > st_q.peak) st_d.peak = out_cnt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CLR;
        else        st_q <= st_d;
    end

    assign now_o     = st_q.now;
    assign beats_o   = st_q.beats;
    assign lat_min_o = st_q.lmin;
    assign lat_max_o = st_q.lmax;
    assign lat_sum_o = st_q.lsum;
    assign occ_sum_o = st_q.osum;
    assign act_cyc_o = st_q.acyc;
    assign peak_o    = st_q.peak;

endmodule

// File: rtl/rd_bench_engine.sv
module rd_bench_engine
    import rbe_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int STRIDE_W = 24,
    parameter int CNT_W    = 32,
    parameter int LAT_W    = 32,
    parameter int SUM_W    = 64,
    parameter int DEPTH    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_start,
    input  logic [ADDR_W-1:0]            cfg_base,
    input  logic [STRIDE_W-1:0]          cfg_stride,
    input  logic [7:0]                   cfg_len,
    input  logic [CNT_W-1:0]             cfg_count,
    input  logic [$clog2(DEPTH+1)-1:0]   cfg_cap,
    output logic                         run_busy,
    output logic                         run_done,
    output logic                         m_arvalid,
    input  logic                         m_arready,
    output logic [ADDR_W-1:0]            m_araddr,
    output logic [7:0]                   m_arlen,
    output logic [2:0]                   m_arsize,
    output logic [1:0]                   m_arburst,
    input  logic                         m_rvalid,
    input  logic                         m_rlast,
    output logic                         m_rready,
    output logic [SUM_W-1:0]             res_beats,
    output logic [LAT_W-1:0]             res_lat_min,
    output logic [LAT_W-1:0]             res_lat_max,
    output logic [SUM_W-1:0]             res_lat_sum,
    output logic [SUM_W-1:0]             res_occ_sum,
    output logic [SUM_W-1:0]             res_act_cyc,
    output logic [$clog2(DEPTH+1)-1:0]   res_peak
);

    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        run_st_e             st;
        logic                done;
        logic [STRIDE_W-1:0] stride;
        logic [AXLEN_W-1:0]  len;
        logic [CNT_W-1:0]    count;
        logic [OCC_W-1:0]    cap;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             launch, running, ar_fire, r_fire, r_last_fire;
    logic             all_issued, finished;
    logic [OCC_W-1:0] out_cnt, out_nxt, cap_in, cap_eff;
    logic [LAT_W-1:0] now, stamp;

    assign running     = (ctl_q.st == ST_RUN);
    assign launch      = cfg_start && !running;
    assign r_fire      = m_rvalid & m_rready;
    assign r_last_fire = r_fire & m_rlast;
    assign out_nxt     = out_cnt + OCC_W'(ar_fire) - OCC_W'(r_last_fire);
    assign finished    = running && all_issued && (out_cnt == '0);
    assign cap_in      = (cfg_cap == '0 || cfg_cap > OCC_W'(DEPTH)) ? OCC_W'(DEPTH) : cfg_cap;
    assign cap_eff     = ctl_q.cap;

    always_comb begin
        ctl_d = ctl_q;
        if (launch) begin
            ctl_d.st     = ST_RUN;
            ctl_d.done   = 1'b0;
            ctl_d.stride = cfg_stride;
            ctl_d.len    = cfg_len;
            ctl_d.count  = cfg_count;
            ctl_d.cap    = cap_in;
        end else if (finished) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, done: 1'b0, stride: '0, len: '0, count: '0, cap: '0};
        else        ctl_q <= ctl_d;
    end

    rbe_addr_gen #(
        .ADDR_W  (ADDR_W),
        .STRIDE_W(STRIDE_W),
        .CNT_W   (CNT_W),
        .OCC_W   (OCC_W)
    ) u_agen (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .run_i       (running),
        .base_i      (cfg_base),
        .stride_i    (ctl_q.stride),
        .len_i       (ctl_q.len),
        .count_i     (ctl_q.count),
        .cap_i       (ctl_q.cap),
        .out_nxt_i   (out_nxt),
        .arready_i   (m_arready),
        .arvalid_o   (m_arvalid),
        .araddr_o    (m_araddr),
        .arlen_o     (m_arlen),
        .fire_o      (ar_fire),
        .all_issued_o(all_issued)
    );

    rbe_stamp_fifo #(
        .W    (LAT_W),
        .DEPTH(DEPTH),
        .OCC_W(OCC_W)
    ) u_stamps (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (launch),
        .push_i (ar_fire),
        .din_i  (now),
        .pop_i  (r_last_fire),
        .dout_o (stamp),
        .count_o(out_cnt)
    );

    rbe_stats #(
        .LAT_W(LAT_W),
        .SUM_W(SUM_W),
        .OCC_W(OCC_W)
    ) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (launch),
        .run_i     (running),
        .finished_i(finished),
        .ar_fire_i (ar_fire),
        .r_fire_i  (r_fire),
        .r_last_i  (r_last_fire),
        .stamp_i   (stamp),
        .out_cnt_i (out_cnt),
        .now_o     (now),
        .beats_o   (res_beats),
        .lat_min_o (res_lat_min),
        .lat_max_o (res_lat_max),
        .lat_sum_o (res_lat_sum),
        .occ_sum_o (res_occ_sum),
        .act_cyc_o (res_act_cyc),
        .peak_o    (res_peak)
    );

    assign m_arsize  = AXSIZE_BEAT;
    assign m_arburst = AXBURST_INCR;
    assign m_rready  = running;
    assign run_busy  = running;
    assign run_done  = ctl_q.done;

endmodule

// File: rtl/rbe_checker.sv
module rbe_checker #(
    parameter int ADDR_W = 40,
    parameter int OCC_W  = 6,
    parameter int LAT_W  = 32,
    parameter int SUM_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arvalid,
    input logic              arready,
    input logic [ADDR_W-1:0] araddr,
    input logic [7:0]        arlen,
    input logic              busy,
    input logic              done,
    input logic [OCC_W-1:0]  out_cnt,
    input logic [OCC_W-1:0]  cap,
    input logic [SUM_W-1:0]  beats,
    input logic [LAT_W-1:0]  lat_min,
    input logic [LAT_W-1:0]  lat_max
);

    a_r4_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen))
        else $error("R4 address request dropped or changed before ready");

    a_r2_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> (9'(araddr[11:6]) + 9'(arlen)) <= 9'd63)
        else $error("R2 burst crosses a 4 KB boundary");

    a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> out_cnt <= cap)
        else $error("R5 outstanding count above cap");

    a_r10_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy && (out_cnt == '0) && !arvalid)
        else $error("R10 done raised with work still in flight");

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arvalid)
        else $error("R10 address request while idle");

    a_r6_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        done && (beats != '0) |-> (lat_min <= lat_max) && (lat_min != '0))
        else $error("R6 latency extrema inconsistent");

endmodule

bind rd_bench_engine rbe_checker #(
    .ADDR_W(ADDR_W),
    .OCC_W ($clog2(DEPTH + 1)),
    .LAT_W (LAT_W),
    .SUM_W (SUM_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .arvalid(m_arvalid),
    .arready(m_arready),
    .araddr (m_araddr),
    .arlen  (m_arlen),
    .busy   (run_busy),
    .done   (run_done),
    .out_cnt(out_cnt),
    .cap    (cap_eff),
    .beats  (res_beats),
    .lat_min(res_lat_min),
    .lat_max(res_lat_max)
);

// File: tb/sim_rd_bench_engine.sv
module sim_rd_bench_engine;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 40;
    localparam int STRIDE_W   = 24;
    localparam int DEPTH      = 32;
    localparam int OCC_W      = $clog2(DEPTH + 1);
    localparam int SLV_DEPTH  = 12;
    localparam int QMAX       = 256;
    localparam int NV         = 7;

    // vector table: base, stride, len, count, cap, max response delay
    localparam logic [39:0] V_BASE [NV] = '{40'h0, 40'h10_0000_0040, 40'hFC0, 40'h2000,
                                            40'h123, 40'hFF_FFFF_FF00, 40'h5000};
    localparam logic [23:0] V_STRD [NV] = '{24'd1, 24'd3, 24'd1, 24'd0, 24'd17, 24'd2, 24'd1};
    localparam logic [7:0]  V_LEN  [NV] = '{8'd0, 8'd3, 8'd7, 8'd255, 8'd15, 8'd1, 8'd0};
    localparam int          V_CNT  [NV] = '{64, 40, 20, 10, 30, 12, 0};
    localparam int          V_CAP  [NV] = '{0, 4, 8, 2, 1, 16, 3};
    localparam int          V_DLY  [NV] = '{20, 30, 10, 5, 3, 8, 4};

    logic                clk = 1'b0;
    logic                rst_n;
    logic                cfg_start;
    logic [ADDR_W-1:0]   cfg_base;
    logic [STRIDE_W-1:0] cfg_stride;
    logic [7:0]          cfg_len;
    logic [31:0]         cfg_count;
    logic [OCC_W-1:0]    cfg_cap;
    logic                run_busy, run_done;
    logic                m_arvalid, m_arready, m_rvalid, m_rlast, m_rready;
    logic [ADDR_W-1:0]   m_araddr;
    logic [7:0]          m_arlen;
    logic [2:0]          m_arsize;
    logic [1:0]          m_arburst;
    logic [63:0]         res_beats, res_lat_sum, res_occ_sum, res_act_cyc;
    logic [31:0]         res_lat_min, res_lat_max;
    logic [OCC_W-1:0]    res_peak;

    rd_bench_engine #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .CNT_W(32), .LAT_W(32), .SUM_W(64), .DEPTH(DEPTH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_base(cfg_base),
        .cfg_stride(cfg_stride), .cfg_len(cfg_len), .cfg_count(cfg_count), .cfg_cap(cfg_cap),
        .run_busy(run_busy), .run_done(run_done), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
        .m_rvalid(m_rvalid), .m_rlast(m_rlast), .m_rready(m_rready), .res_beats(res_beats),
        .res_lat_min(res_lat_min), .res_lat_max(res_lat_max), .res_lat_sum(res_lat_sum),
        .res_occ_sum(res_occ_sum), .res_act_cyc(res_act_cyc), .res_peak(res_peak)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int nchk = 0;
    int nfail = 0;

    // responder model state
    int          ecnt = 0;
    int          hd, tl, acc_n, bidx;
    int          q_t [QMAX];
    int          q_len [QMAX];
    int          q_dly [QMAX];
    logic [63:0] m_beats, m_lsum;
    logic [31:0] m_min, m_max;
    int          m_peak, first_t, last_t, addr_err, rdy_err, m_dly;
    logic [39:0] m_base;
    logic [23:0] m_stride;
    logic [7:0]  m_len;

    function automatic logic [39:0] m_addr(input int k);
        return (m_base & ~40'h3F) + 40'(k) * 40'(m_stride) * 40'd64;
    endfunction

    function automatic logic [7:0] m_clip(input logic [39:0] a);
        logic [7:0] lim;
        lim = 8'd63 - 8'(a[11:6]);
        return (m_len > lim) ? lim : m_len;
    endfunction

    task automatic clr_model();
        hd = 0; tl = 0; acc_n = 0; bidx = 0;
        m_beats = '0; m_lsum = '0; m_min = '1; m_max = '0;
        m_peak = 0; first_t = -1; last_t = -1; addr_err = 0; rdy_err = 0;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural AXI read responder, in-order, bounded acceptance
    initial begin
        m_arready = 1'b0; m_rvalid = 1'b0; m_rlast = 1'b0;
        clr_model();
        m_dly = 1; m_base = '0; m_stride = '0; m_len = '0;
        forever begin
            @(posedge clk);
            ecnt++;
            if (!rst_n) begin
                m_arready <= 1'b0; m_rvalid <= 1'b0; m_rlast <= 1'b0;
            end else begin
                if (m_rready !== run_busy) rdy_err++;
                if (m_arvalid && m_arready) begin
                    if (m_araddr !== m_addr(acc_n) || m_arlen !== m_clip(m_addr(acc_n)) ||
                        m_arsize !== 3'd6 || m_arburst !== 2'b01) addr_err++;
                    if (tl < QMAX) begin
                        q_len[tl] = int'(m_arlen);
                        q_t[tl]   = ecnt;
                        q_dly[tl] = int'($urandom_range(m_dly, 1));
                        tl++;
                    end
                    if (first_t < 0) first_t = ecnt;
                    acc_n++;
                end
                if (m_rvalid) begin
                    if (!m_rready) rdy_err++;
                    m_beats++;
                    if (m_rlast) begin
                        if (32'(ecnt - q_t[hd]) < m_min) m_min = 32'(ecnt - q_t[hd]);
                        if (32'(ecnt - q_t[hd]) > m_max) m_max = 32'(ecnt - q_t[hd]);
                        m_lsum += 64'(ecnt - q_t[hd]);
                        hd++; bidx = 0; last_t = ecnt;
                    end else begin
                        bidx++;
                    end
                end
                if (tl - hd > m_peak) m_peak = tl - hd;
                m_arready <= (tl - hd < SLV_DEPTH) && ($urandom_range(3, 0) != 0);
                if (hd < tl && ecnt >= q_t[hd] + q_dly[hd] && $urandom_range(3, 0) != 0) begin
                    m_rvalid <= 1'b1;
                    m_rlast  <= (bidx == q_len[hd]);
                end else begin
                    m_rvalid <= 1'b0;
                    m_rlast  <= 1'b0;
                end
            end
        end
    end

    task automatic run_vec(input logic [39:0] b, input logic [23:0] s, input logic [7:0] l,
                           input int cnt, input int cap, input int dly, input bit poke);
        logic [63:0] exp_beats;
        int          ecap;
        int          guard;
        @(negedge clk);
        clr_model();
        m_base = b; m_stride = s; m_len = l; m_dly = dly;
        cfg_base = b; cfg_stride = s; cfg_len = l; cfg_count = cnt; cfg_cap = OCC_W'(cap);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        if (poke) begin
            repeat (15) @(negedge clk);
            chk("R11 busy before ignored start", 64'(run_busy), 64'd1);
            cfg_base = 40'h77_0000_0000; cfg_stride = 24'd5; cfg_count = 3; cfg_len = 8'd9;
            cfg_start = 1'b1;
            @(negedge clk);
            cfg_start = 1'b0;
        end
        guard = 0;
        while (!run_done && guard < 100000) begin
            @(negedge clk);
            guard++;
        end
        exp_beats = '0;
        for (int k = 0; k < cnt; k++) exp_beats += 64'(m_clip(m_addr(k))) + 64'd1;
        ecap = (cap == 0 || cap > DEPTH) ? DEPTH : cap;
        chk("R10 done after run", 64'(run_done), 64'd1);
        chk("R10 busy low after run", 64'(run_busy), 64'd0);
        chk("R3 requests accepted", 64'(acc_n), 64'(cnt));
        chk("R3 beat count", res_beats, exp_beats);
        chk("R3 beats seen by responder", m_beats, exp_beats);
        chk("R1 R2 address and length errors", 64'(addr_err), 64'd0);
        chk("R9 rready span errors", 64'(rdy_err), 64'd0);
        chk("R6 latency minimum", 64'(res_lat_min), 64'(m_min));
        chk("R6 latency maximum", 64'(res_lat_max), 64'(m_max));
        chk("R6 latency sum", res_lat_sum, m_lsum);
        chk("R7 occupancy sum", res_occ_sum, m_lsum);
        chk("R7 active cycles", res_act_cyc, (cnt == 0) ? 64'd0 : 64'(last_t - first_t));
        chk("R8 peak in flight", 64'(res_peak), 64'(m_peak));
        chk("R5 peak within cap", 64'(m_peak <= ecap), 64'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_start = 1'b0; cfg_base = '0; cfg_stride = '0;
        cfg_len = '0; cfg_count = '0; cfg_cap = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 busy", 64'(run_busy), 64'd0);
        chk("R13 done", 64'(run_done), 64'd0);
        chk("R13 arvalid", 64'(m_arvalid), 64'd0);
        chk("R13 rready", 64'(m_rready), 64'd0);
        chk("R13 beats", res_beats, 64'd0);
        chk("R13 latency minimum", 64'(res_lat_min), 64'hFFFF_FFFF);
        chk("R13 peak", 64'(res_peak), 64'd0);

        for (int v = 0; v < NV; v++) begin
            run_vec(V_BASE[v], V_STRD[v], V_LEN[v], V_CNT[v], V_CAP[v], V_DLY[v], 1'b0);
        end

        // R10 done holds while idle
        repeat (5) @(negedge clk);
        chk("R10 done held", 64'(run_done), 64'd1);
        chk("R10 no request while idle", 64'(m_arvalid), 64'd0);

        // R11 start pulse during a run has no effect
        run_vec(40'h3_0000, 24'd2, 8'd3, 30, 6, 25, 1'b1);

        // R12 empty run after a full one
        run_vec(40'h8000, 24'd1, 8'd0, 0, 0, 4, 1'b0);
        chk("R12 empty run beats", res_beats, 64'd0);
        chk("R12 empty run minimum", 64'(res_lat_min), 64'hFFFF_FFFF);
        chk("R12 empty run occupancy", res_occ_sum, 64'd0);

        // R5 single outstanding request with long delays
        run_vec(40'h40, 24'd1, 8'd2, 8, 1, 40, 1'b0);
        chk("R5 single cap peak", 64'(res_peak), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule